// File: doc/BRIEF.md
# Interrupt Status and Enable Register Block

This block gathers single-cycle event pulses from a serial shift engine and its FIFOs into a sticky status word. Each status bit is gated by an enable bit at the same position in a control word, and the gated bits are ORed into one interrupt line. Software reads either word through a simple register port. It clears status bits by writing ones and rewrites the control word to change enables.

The control word also carries two more bits. One enables generation of the receive-trigger event itself. The other requests a soft reset of the serial logic. A two-state machine holds the soft-reset condition. In `CTL_ACTIVE` events are captured normally. A control write with bit 28 set takes the transition `enter_reset` to `CTL_SRST`. In that state the status word is flushed and held at zero, events are ignored, and the enables are kept. A control write with bit 28 clear takes the transition `leave_reset` back to `CTL_ACTIVE`. A write whose bit 28 matches the current state causes no transition.

Top module: `irq_status_ctl`

## Requirements
- R1: After reset the control word, the status word and `irq` are all zero and the machine is in `CTL_ACTIVE`.
- R2: In `CTL_ACTIVE`, an event high at a clock edge sets its status bit, readable from the next cycle, whether or not its enable is set. The bit positions are: receive trigger 0, transmit trigger 4, word end 8, transmit end 9, overflow 12, underrun 13.
- R3: A status bit stays set after its event drops, until it is cleared by a write or by soft reset.
- R4: A write with `reg_sel`=1 clears each status bit whose data bit is one and leaves bits written zero unchanged. If an event arrives in the same cycle as the clear of its bit, the bit ends up set.
- R5: `irq` is high exactly when some status bit is set and the control bit at the same position (0, 4, 8, 9, 12 or 13) is one. It follows the registers with no extra delay.
- R6: The receive-trigger event is captured only while control bit 19 is one.
- R7: Control bit 28 is the soft reset. While it reads one, `soft_rst` is high, the status word reads zero from the following cycle, and events are ignored. Enables and bit 19 keep their values across entering and leaving soft reset.
- R8: A write with `reg_sel`=0 replaces control bits 0, 4, 8, 9, 12, 13, 19 and 28. All other bits of both words read zero. `reg_rdata` shows the word chosen by `reg_sel` (0 control, 1 status) combinationally.
- R9: The overflow event is captured only while `full_duplex` is high, because overflow can only happen when transmission and reception run together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_sel | input | 1 | Word select: 0 control, 1 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| ev_rx_trig | input | 1 | Receive FIFO reached its trigger level |
| ev_tx_trig | input | 1 | Transmit trigger event |
| ev_word_end | input | 1 | One serial word finished |
| ev_tx_end | input | 1 | Transmit FIFO drained to empty |
| ev_overflow | input | 1 | Receive overflow |
| ev_underrun | input | 1 | Transmit underrun |
| full_duplex | input | 1 | Transmit and receive running together |
| soft_rst | output | 1 | Soft reset request to the serial engine |
| irq | output | 1 | Interrupt line |

## Verification
Events and register writes take effect at one clock edge. The status word, the control word, `soft_rst` and `irq` therefore change in the cycle that follows that edge, and `reg_rdata` follows `reg_sel` within the same cycle. The bench drives its inputs while the clock is low and lets one rising edge pass. It then reads both words, `irq` and `soft_rst` on the falling edge, changing `reg_sel` between the two reads. Each sample is compared against a model updated once per edge from the values that were held across that edge. The status flush under soft reset starts one edge after the write that sets bit 28, and the checks sample two cycles after that write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int REG_W     = 32;
    localparam int NSRC      = 6;
    localparam int RXGEN_POS = 19;
    localparam int SRST_POS  = 28;

    // source indices inside the event vector
    localparam int SRC_RXTRIG   = 0;
    localparam int SRC_TXTRIG   = 1;
    localparam int SRC_WORDEND  = 2;
    localparam int SRC_TXEND    = 3;
    localparam int SRC_OVERFLOW = 4;
    localparam int SRC_UNDERRUN = 5;

    typedef enum logic {
        CTL_ACTIVE = 1'b0,
        CTL_SRST   = 1'b1
    } ctl_state_e;

    // bit position of each source in both register words
    function automatic int src_pos(input int idx);
        case (idx)
            SRC_RXTRIG:   return 0;
            SRC_TXTRIG:   return 4;
            SRC_WORDEND:  return 8;
            SRC_TXEND:    return 9;
            SRC_OVERFLOW: return 12;
            default:      return 13;
        endcase
    endfunction
endpackage

// File: rtl/irqc_src_gate.sv
module irqc_src_gate
    import irqc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] ev_raw,
    input  logic         rxgen_en,
    input  logic         full_duplex,
    input  logic         capture_en,
    output logic [N-1:0] ev_gated
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_src
            if (g == SRC_RXTRIG) begin : g_rx
                assign ev_gated[g] = ev_raw[g] & rxgen_en & capture_en;
            end else if (g == SRC_OVERFLOW) begin : g_ovf
                assign ev_gated[g] = ev_raw[g] & full_duplex & capture_en;
            end else begin : g_plain
                assign ev_gated[g] = ev_raw[g] & capture_en;
            end
        end
    endgenerate
endmodule

// File: rtl/irqc_status_bit.sv
module irqc_status_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic set_ev,
    input  logic clr_w1,
    output logic stat_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (flush) begin
            stat_q <= 1'b0;
        end else if (set_ev) begin
            stat_q <= 1'b1;        // a new event wins over a clear in the same cycle
        end else if (clr_w1) begin
            stat_q <= 1'b0;
        end
    end
endmodule

// File: rtl/irqc_ctrl_fsm.sv
module irqc_ctrl_fsm
    import irqc_pkg::*;
#(
    parameter int N = NSRC,
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_wr,
    input  logic [W-1:0] wdata,
    output logic [N-1:0] en_q,
    output logic         rxgen_q,
    output logic         srst_active,
    output logic         capture_en
);
    ctl_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_ACTIVE;
        else        state_q <= state_d;
    end

    // transitions: enter_reset and leave_reset
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_ACTIVE: if (ctrl_wr &&  wdata[SRST_POS]) state_d = CTL_SRST;
            CTL_SRST:   if (ctrl_wr && !wdata[SRST_POS]) state_d = CTL_ACTIVE;
        endcase
    end

    // outputs
    always_comb begin
        srst_active = 1'b0;
        capture_en  = 1'b1;
        unique case (state_q)
            CTL_ACTIVE: begin
                srst_active = 1'b0;
                capture_en  = 1'b1;
            end
            CTL_SRST: begin
                srst_active = 1'b1;
                capture_en  = 1'b0;
            end
        endcase
    end

    // enable bits survive soft reset; only a control write changes them
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            rxgen_q <= 1'b0;
        end else if (ctrl_wr) begin
            for (int i = 0; i < N; i++) en_q[i] <= wdata[src_pos(i)];
            rxgen_q <= wdata[RXGEN_POS];
        end
    end
endmodule

// File: rtl/irq_status_ctl.sv
module irq_status_ctl
    import irqc_pkg::*;
#(
    parameter int W = REG_W,
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic         reg_sel,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         ev_rx_trig,
    input  logic         ev_tx_trig,
    input  logic         ev_word_end,
    input  logic         ev_tx_end,
    input  logic         ev_overflow,
    input  logic         ev_underrun,
    input  logic         full_duplex,
    output logic         soft_rst,
    output logic         irq
);
    logic [N-1:0] ev_raw, ev_gated, en_q, stat_q, clr_vec;
    logic         rxgen_q, srst_active, capture_en;
    logic         ctrl_wr, stat_wr;
    logic [W-1:0] ctrl_word, stat_word;

    assign ctrl_wr = reg_wr & ~reg_sel;
    assign stat_wr = reg_wr &  reg_sel;

    assign ev_raw[SRC_RXTRIG]   = ev_rx_trig;
    assign ev_raw[SRC_TXTRIG]   = ev_tx_trig;
    assign ev_raw[SRC_WORDEND]  = ev_word_end;
    assign ev_raw[SRC_TXEND]    = ev_tx_end;
    assign ev_raw[SRC_OVERFLOW] = ev_overflow;
    assign ev_raw[SRC_UNDERRUN] = ev_underrun;

    irqc_ctrl_fsm #(.N(N), .W(W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .wdata       (reg_wdata),
        .en_q        (en_q),
        .rxgen_q     (rxgen_q),
        .srst_active (srst_active),
        .capture_en  (capture_en)
    );

    irqc_src_gate #(.N(N)) u_gate (
        .ev_raw      (ev_raw),
        .rxgen_en    (rxgen_q),
        .full_duplex (full_duplex),
        .capture_en  (capture_en),
        .ev_gated    (ev_gated)
    );

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_stat
            assign clr_vec[g] = stat_wr & reg_wdata[src_pos(g)];
            irqc_status_bit u_bit (
                .clk    (clk),
                .rst_n  (rst_n),
                .flush  (srst_active),
                .set_ev (ev_gated[g]),
                .clr_w1 (clr_vec[g]),
                .stat_q (stat_q[g])
            );
        end
    endgenerate

    always_comb begin
        ctrl_word = '0;
        stat_word = '0;
        for (int i = 0; i < N; i++) begin
            ctrl_word[src_pos(i)] = en_q[i];
            stat_word[src_pos(i)] = stat_q[i];
        end
        ctrl_word[RXGEN_POS] = rxgen_q;
        ctrl_word[SRST_POS]  = srst_active;
    end

    assign reg_rdata = reg_sel ? stat_word : ctrl_word;
    assign irq       = |(stat_q & en_q);
    assign soft_rst  = srst_active;
endmodule

// File: rtl/irq_status_ctl_chk.sv
module irq_status_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        stat_clr8,
    input logic        stat_clr9,
    input logic        ev_tx_end,
    input logic        ev_underrun,
    input logic        full_duplex,
    input logic        soft_rst,
    input logic        irq,
    input logic        rxgen,
    input logic [31:0] stat_word
);
    assert_underrun_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && ev_underrun) |=> stat_word[13]);

    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && stat_word[8] && !stat_clr8) |=> stat_word[8]);

    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && stat_word[9] && stat_clr9 && !ev_tx_end) |=> !stat_word[9]);

    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_word != 32'd0));

    assert_rxgen_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rxgen && !stat_word[0]) |=> !stat_word[0]);

    assert_srst_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (stat_word == 32'd0));

    assert_ovf_duplex_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_duplex && !stat_word[12]) |=> !stat_word[12]);
endmodule

bind irq_status_ctl irq_status_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stat_clr8   (stat_wr & reg_wdata[8]),
    .stat_clr9   (stat_wr & reg_wdata[9]),
    .ev_tx_end   (ev_tx_end),
    .ev_underrun (ev_underrun),
    .full_duplex (full_duplex),
    .soft_rst    (soft_rst),
    .irq         (irq),
    .rxgen       (rxgen_q),
    .stat_word   (stat_word)
);

// File: tb/irq_status_ctl_bench.sv
module irq_status_ctl_bench;
    localparam logic [31:0] EN_MASK   = 32'h0000_3311;
    localparam logic [31:0] CTRL_MASK = 32'h1008_3311;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [5:0]  ev = '0;
    logic        full_duplex = 1'b0;
    logic        soft_rst, irq;

    int checks = 0, errors = 0;
    logic [31:0] m_stat = '0, m_ctrl = '0;

    always #2.5 clk = ~clk;

    irq_status_ctl u_irq_status_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_rx_trig(ev[0]), .ev_tx_trig(ev[1]), .ev_word_end(ev[2]),
        .ev_tx_end(ev[3]), .ev_overflow(ev[4]), .ev_underrun(ev[5]),
        .full_duplex(full_duplex), .soft_rst(soft_rst), .irq(irq)
    );

    // event vector -> status positions 0,4,8,9,12,13
    function automatic logic [31:0] ev_word(input logic [5:0] e);
        logic [31:0] w = '0;
        w[0] = e[0]; w[4] = e[1]; w[8] = e[2];
        w[9] = e[3]; w[12] = e[4]; w[13] = e[5];
        return w;
    endfunction

    function automatic logic exp_irq(input logic [31:0] s, input logic [31:0] c);
        return |(s & c & EN_MASK);
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // model of one edge, using values held across it
    task automatic model_edge;
        logic [31:0] sets, clr;
        logic [5:0]  e;
        e = ev;
        if (!m_ctrl[19]) e[0] = 1'b0;
        if (!full_duplex) e[4] = 1'b0;
        sets = ev_word(e);
        clr  = (reg_wr && reg_sel) ? (reg_wdata & EN_MASK) : 32'd0;
        if (m_ctrl[28]) m_stat = '0;
        else            m_stat = sets | (m_stat & ~clr);
        if (reg_wr && !reg_sel) m_ctrl = reg_wdata & CTRL_MASK;
    endtask

    task automatic step(input logic wr, input logic sel, input logic [31:0] wd,
                        input logic [5:0] e, input logic dup, input string tag);
        reg_wr = wr; reg_sel = sel; reg_wdata = wd; ev = e; full_duplex = dup;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        reg_wr = 1'b0; ev = '0;
        reg_sel = 1'b1; #0.5;
        check(reg_rdata, m_stat, {tag, " status"});
        reg_sel = 1'b0; #0.5;
        check(reg_rdata, m_ctrl, {tag, " control"});
        check({31'd0, irq}, {31'd0, exp_irq(m_stat, m_ctrl)}, {tag, " irq"});
        check({31'd0, soft_rst}, {31'd0, m_ctrl[28]}, {tag, " soft_rst"});
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        reg_sel = 1'b1; #0.5; check(reg_rdata, 32'd0, "R1 status");
        reg_sel = 1'b0; #0.5; check(reg_rdata, 32'd0, "R1 control");
        check({31'd0, irq}, 32'd0, "R1 irq");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: underrun sets bit 13 with enable off; R3: it stays
        step(0, 0, 0, 6'b100000, 0, "R2");
        check(m_stat, 32'h0000_2000, "R2 model");
        step(0, 0, 0, 6'b000000, 0, "R3");
        // R5: enable bit 13 raises irq
        step(1, 0, 32'h0000_2000, 6'b0, 0, "R5");
        check({31'd0, irq}, 32'd1, "R5 irq direct");
        // R4: write zero leaves, write one clears
        step(1, 1, 32'h0000_0000, 6'b0, 0, "R4 zero");
        step(1, 1, 32'h0000_2000, 6'b0, 0, "R4 clear");
        // R4: event wins over same-cycle clear
        step(0, 0, 0, 6'b001000, 0, "R4 pre");
        step(1, 1, 32'h0000_0200, 6'b001000, 0, "R4 race");
        check(m_stat & 32'h200, 32'h200, "R4 race model");
        // R6: rx trigger gated by bit 19
        step(1, 1, 32'hFFFF_FFFF, 6'b0, 0, "R4 clear all");
        step(0, 0, 0, 6'b000001, 0, "R6 off");
        step(1, 0, 32'h0008_0001, 6'b0, 0, "R6 enable");
        step(0, 0, 0, 6'b000001, 0, "R6 on");
        // R9: overflow needs full duplex
        step(0, 0, 0, 6'b010000, 0, "R9 half");
        step(0, 0, 0, 6'b010000, 1, "R9 full");
        // R8: reserved bits read zero
        step(1, 0, 32'hEFFF_FFFF, 6'b0, 0, "R8 write");
        check(reg_rdata, 32'h0008_3311, "R8 readback");
        // R7: soft reset flushes, ignores events, keeps enables
        step(1, 0, 32'hFFFF_FFFF, 6'b111111, 1, "R7 enter");
        step(0, 0, 0, 6'b111111, 1, "R7 flush");
        step(0, 0, 0, 6'b111111, 1, "R7 hold");
        step(1, 0, 32'h0008_3311, 6'b0, 1, "R7 leave");
        step(0, 0, 0, 6'b000100, 1, "R7 after");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic        wr, sel;
            logic [31:0] wd;
            wr  = ($urandom_range(0, 3) == 0);
            sel = $urandom_range(0, 1);
            wd  = $urandom();
            if (!sel && $urandom_range(0, 7) != 0) wd[28] = 1'b0;
            step(wr, sel, wd, 6'($urandom() & $urandom()), 1'($urandom_range(0, 1)),
                 "R2/R3/R4/R5 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule